// File: doc/BRIEF.md
# SDRAM Command Issuer with Bank State Tracking

This block sits between a host that posts one request at a time and the control pins of a single SDRAM device. Each accepted request becomes one encoded command on the active-low chip select, row strobe, column strobe and write enable pins. The row or column address goes out on the multiplexed address bus and the bank number on the bank bus. The block supports these requests: programming the mode register, opening a row, reading, writing, closing one bank, closing every bank, auto refresh, and entering or leaving self refresh. When no command is due, the pins are held at deselect.

A small table keeps, for every bank, whether a row is open and which row that is. The block checks column commands and activates against this table. A request that the table shows to be illegal is not sent to the device. Instead it raises a one-cycle error pulse. The mode word is built inside the block: only the CAS latency comes from the host, and burst length two with interleaved ordering is always encoded. The clock enable pin is dropped together with the refresh command when self refresh is entered. It is raised again on exit, and all banks are then treated as idle.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: After reset the pins show deselect ({cs_n,ras_n,cas_n,we_n} = 1111), cke is 1, req_ready is 1, err is 0 and every bank is idle.
- R2: A mode request (op 0) with a nonzero latency drives pin code 0000, ba = 0, ma[12:7] = 0, ma[6:4] = the requested CAS latency, ma[3] = 1 (interleave) and ma[2:0] = 001 (burst of two).
- R3: A mode request whose CAS latency is 000 is rejected: err pulses and the pins stay at deselect.
- R4: An activate (op 1) to an idle bank drives pin code 0011 with the row on ma and the bank on ba, and it marks that bank open. An activate to a bank that is already open raises err and issues nothing.
- R5: A read (op 2) or a write (op 3) to an open bank drives pin code 0101 or 0100 respectively. The column goes on ma with ma[10] forced to 0, and the bank goes on ba.
- R6: A read or a write to an idle bank raises err and leaves the pins at deselect.
- R7: A single-bank precharge (op 4) drives pin code 0010 with ma = 0 (ma[10] low) and ba = the bank. Only that bank becomes idle.
- R8: An all-bank precharge (op 5) drives pin code 0010 with ma[10] = 1, every other ma bit 0 and ba = 0. Every bank becomes idle.
- R9: An auto refresh (op 6) drives pin code 0001 while cke stays 1.
- R10: A self-refresh request (op 7) outside self refresh drives pin code 0001 with cke 0 in the same cycle, and cke then stays 0. While in self refresh, any op other than 7 raises err and drives nothing. Op 7 then raises cke with the pins at deselect, and all banks are idle afterwards.
- R11: An accepted request drives its command during exactly the one cycle that follows the accepting clock edge. req_ready is 0 during that cycle, and the pins return to deselect once it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_op | input | 3 | Request code (0 mode, 1 activate, 2 read, 3 write, 4 close one, 5 close all, 6 refresh, 7 self refresh enter/exit) |
| req_bank | input | BANK_W | Target bank |
| req_addr | input | ADDR_W | Row for activate, column for read/write |
| req_cas_lat | input | 3 | CAS latency for the mode word |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| err | output | 1 | One-cycle pulse for a rejected request |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| ma | output | ADDR_W | Multiplexed address |
| ba | output | BANK_W | Bank address |

## Verification
Every result of a request is due in the single cycle after the clock edge that accepts it. This covers the pin code, ma, ba, the err pulse, the drop in req_ready and the cke change for self refresh. The bank table is updated on that same edge. Each directed task therefore presents the request before one rising edge, samples all outputs at the following falling edge, and checks at the next falling edge that the pins are back at deselect and req_ready is high again. The effect of a bank-state change is checked through the accept or reject outcome of the request that follows.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    OP_MODE     = 3'd0,
    OP_ACT      = 3'd1,
    OP_READ     = 3'd2,
    OP_WRITE    = 3'd3,
    OP_PRE_ONE  = 3'd4,
    OP_PRE_ALL  = 3'd5,
    OP_REFRESH  = 3'd6,
    OP_SELF     = 3'd7
  } req_op_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    PIN_MRS  = 4'b0000,
    PIN_REF  = 4'b0001,
    PIN_PRE  = 4'b0010,
    PIN_ACT  = 4'b0011,
    PIN_WR   = 4'b0100,
    PIN_RD   = 4'b0101,
    PIN_DESL = 4'b1111
  } pin_cmd_e;

  localparam int ALLBANK_BIT = 10;
  localparam int MODE_BITS   = 7;

  // Low seven mode bits: latency, interleave flag, burst-of-two code.
  function automatic logic [MODE_BITS-1:0] mode_low_bits(input logic [2:0] cas_lat);
    return {cas_lat, 1'b1, 3'b001};
  endfunction

  function automatic logic cas_lat_ok(input logic [2:0] cas_lat);
    return cas_lat != 3'b000;
  endfunction

endpackage

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en,
  input  logic [BANK_W-1:0]        sel_bank,
  input  logic [ADDR_W-1:0]        row_in,
  input  logic                     set_open,
  input  logic                     clr_one,
  input  logic                     clr_all,
  output logic [BANKS-1:0]         open_vec,
  output logic [BANKS*ADDR_W-1:0]  row_flat
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              open_q;
    logic [ADDR_W-1:0] row_q;
    logic              hit;

    assign hit = upd_en && (sel_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (upd_en && clr_all) begin
        open_q <= 1'b0;
      end else if (hit && clr_one) begin
        open_q <= 1'b0;
      end else if (hit && set_open) begin
        open_q <= 1'b1;
        row_q  <= row_in;
      end
    end

    assign open_vec[b] = open_q;
    assign row_flat[b*ADDR_W +: ADDR_W] = row_q;
  end

endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic [2:0]         op,
  input  logic [BANK_W-1:0]  bank,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [2:0]         cas_lat,
  input  logic [BANKS-1:0]   open_vec,
  input  logic               in_self,
  output pin_cmd_e           cmd,
  output logic [ADDR_W-1:0]  ma_out,
  output logic [BANK_W-1:0]  ba_out,
  output logic               legal,
  output logic               set_open,
  output logic               clr_one,
  output logic               clr_all,
  output logic               self_enter,
  output logic               self_exit
);

  logic bank_open;
  assign bank_open = open_vec[bank];

  always_comb begin
    cmd        = PIN_DESL;
    ma_out     = '0;
    ba_out     = '0;
    legal      = 1'b1;
    set_open   = 1'b0;
    clr_one    = 1'b0;
    clr_all    = 1'b0;
    self_enter = 1'b0;
    self_exit  = 1'b0;
    if (in_self) begin
      if (op == OP_SELF) begin
        self_exit = 1'b1;
        clr_all   = 1'b1;
      end else begin
        legal = 1'b0;
      end
    end else begin
      case (op)
        OP_MODE: begin
          if (cas_lat_ok(cas_lat)) begin
            cmd                      = PIN_MRS;
            ma_out[MODE_BITS-1:0]    = mode_low_bits(cas_lat);
          end else begin
            legal = 1'b0;
          end
        end
        OP_ACT: begin
          if (!bank_open) begin
            cmd      = PIN_ACT;
            ma_out   = addr;
            ba_out   = bank;
            set_open = 1'b1;
          end else begin
            legal = 1'b0;
          end
        end
        OP_READ, OP_WRITE: begin
          if (bank_open) begin
            cmd                 = (op == OP_READ) ? PIN_RD : PIN_WR;
            ma_out              = addr;
            ma_out[ALLBANK_BIT] = 1'b0;
            ba_out              = bank;
          end else begin
            legal = 1'b0;
          end
        end
        OP_PRE_ONE: begin
          cmd     = PIN_PRE;
          ba_out  = bank;
          clr_one = 1'b1;
        end
        OP_PRE_ALL: begin
          cmd                 = PIN_PRE;
          ma_out[ALLBANK_BIT] = 1'b1;
          clr_all             = 1'b1;
        end
        OP_REFRESH: cmd = PIN_REF;
        default: begin
          cmd        = PIN_REF;
          self_enter = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_cas_lat,
  output logic              req_ready,
  output logic              err,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [ADDR_W-1:0] ma,
  output logic [BANK_W-1:0] ba
);

  localparam int BANKS = 1 << BANK_W;

  // Named internal events, also observed by the bound checker.
  logic                    accept;
  logic [BANKS-1:0]        bank_open;
  logic [BANKS*ADDR_W-1:0] open_rows;
  logic                    in_self_q;

  pin_cmd_e          dec_cmd;
  logic [ADDR_W-1:0] dec_ma;
  logic [BANK_W-1:0] dec_ba;
  logic dec_legal, dec_set, dec_clr_one, dec_clr_all, dec_enter, dec_exit;

  pin_cmd_e          pins_q;
  logic [ADDR_W-1:0] ma_q;
  logic [BANK_W-1:0] ba_q;
  logic              cke_q, ready_q, err_q;

  assign accept = req_valid && ready_q;

  sdram_cmd_decode #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) dec_i (
    .op         (req_op),
    .bank       (req_bank),
    .addr       (req_addr),
    .cas_lat    (req_cas_lat),
    .open_vec   (bank_open),
    .in_self    (in_self_q),
    .cmd        (dec_cmd),
    .ma_out     (dec_ma),
    .ba_out     (dec_ba),
    .legal      (dec_legal),
    .set_open   (dec_set),
    .clr_one    (dec_clr_one),
    .clr_all    (dec_clr_all),
    .self_enter (dec_enter),
    .self_exit  (dec_exit)
  );

  sdram_bank_table #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) tbl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (accept && dec_legal),
    .sel_bank (req_bank),
    .row_in   (req_addr),
    .set_open (dec_set),
    .clr_one  (dec_clr_one),
    .clr_all  (dec_clr_all),
    .open_vec (bank_open),
    .row_flat (open_rows)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_q    <= PIN_DESL;
      ma_q      <= '0;
      ba_q      <= '0;
      cke_q     <= 1'b1;
      ready_q   <= 1'b1;
      err_q     <= 1'b0;
      in_self_q <= 1'b0;
    end else begin
      pins_q  <= PIN_DESL;
      ma_q    <= '0;
      ba_q    <= '0;
      err_q   <= 1'b0;
      ready_q <= !accept;
      if (accept) begin
        if (dec_legal) begin
          pins_q <= dec_cmd;
          ma_q   <= dec_ma;
          ba_q   <= dec_ba;
          if (dec_enter) begin
            cke_q     <= 1'b0;
            in_self_q <= 1'b1;
          end
          if (dec_exit) begin
            cke_q     <= 1'b1;
            in_self_q <= 1'b0;
          end
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = pins_q;
  assign ma        = ma_q;
  assign ba        = ba_q;
  assign cke       = cke_q;
  assign req_ready = ready_q;
  assign err       = err_q;

endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
module sdram_cmd_issuer_chk
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  localparam int BANKS = 1 << BANK_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    accept,
  input logic                    req_ready,
  input logic                    err,
  input logic                    cke,
  input logic                    cs_n,
  input logic                    ras_n,
  input logic                    cas_n,
  input logic                    we_n,
  input logic [ADDR_W-1:0]       ma,
  input logic [BANK_W-1:0]       ba,
  input logic [BANKS-1:0]        bank_open,
  input logic [BANKS*ADDR_W-1:0] open_rows
);

  logic [3:0] pins;
  assign pins = {cs_n, ras_n, cas_n, we_n};

  assert_idle_desel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> (pins == PIN_DESL));

  assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_err_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (pins == PIN_DESL));

  assert_mode_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == PIN_MRS) |-> (ba == '0 && ma[2:0] == 3'b001 && ma[3] && ma[6:4] != 3'b000));

  assert_act_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == PIN_ACT) |-> (bank_open[ba] && open_rows[int'(ba)*ADDR_W +: ADDR_W] == ma));

  assert_col_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == PIN_RD || pins == PIN_WR) |-> (bank_open[ba] && !ma[ALLBANK_BIT]));

  assert_pre_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == PIN_PRE && !ma[ALLBANK_BIT]) |-> !bank_open[ba]);

  assert_pre_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == PIN_PRE && ma[ALLBANK_BIT]) |-> (bank_open == '0));

  assert_cke_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (pins == PIN_REF));

  assert_cke_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (pins == PIN_DESL && bank_open == '0));

endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .req_ready (req_ready),
  .err       (err),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ma        (ma),
  .ba        (ba),
  .bank_open (bank_open),
  .open_rows (open_rows)
);

// File: tb/sdram_cmd_issuer_tb.sv
module sdram_cmd_issuer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_addr = '0;
  logic [2:0]  req_cas_lat = '0;
  logic        req_ready, err, cs_n, ras_n, cas_n, we_n, cke;
  logic [12:0] ma;
  logic [1:0]  ba;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  sdram_cmd_issuer #(.BANK_W(2), .ADDR_W(13)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_addr(req_addr), .req_cas_lat(req_cas_lat),
    .req_ready(req_ready), .err(err), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .ma(ma), .ba(ba)
  );

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_DESL = 4'b1111;

  function automatic logic [3:0] pins();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Present one request, then check the cycle after acceptance and the one after.
  task automatic issue(input logic [2:0] op, input int bank, input int addr, input int cl,
                       input logic [3:0] ep, input int ema, input int eba,
                       input logic eerr, input logic ecke, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bank = bank[1:0];
    req_addr = addr[12:0]; req_cas_lat = cl[2:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rq, "pins", int'(pins()), int'(ep));
    if (!eerr) begin
      check(rq, "ma", int'(ma), ema);
      check(rq, "ba", int'(ba), eba);
    end
    check(rq, "err", int'(err), int'(eerr));
    check(rq, "cke", int'(cke), int'(ecke));
    check("R11", "ready_low", int'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check("R11", "desel_after", int'(pins()), int'(C_DESL));
    check("R11", "ready_back", int'(req_ready), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "pins", int'(pins()), int'(C_DESL));
    check("R1", "cke", int'(cke), 1);
    check("R1", "ready", int'(req_ready), 1);
    check("R1", "err", int'(err), 0);
    // all idle: reads to banks 0 and 3 are rejected
    issue(3'd2, 0, 0, 0, C_DESL, 0, 0, 1'b1, 1'b1, "R1");
    issue(3'd2, 3, 0, 0, C_DESL, 0, 0, 1'b1, 1'b1, "R1");
  endtask

  task automatic t_mode();
    issue(3'd0, 2, 13'h1FFF, 3, C_MRS, 13'h039, 0, 1'b0, 1'b1, "R2");
    issue(3'd0, 0, 0, 7, C_MRS, 13'h079, 0, 1'b0, 1'b1, "R2");
    issue(3'd0, 0, 0, 1, C_MRS, 13'h019, 0, 1'b0, 1'b1, "R2");
    issue(3'd0, 1, 0, 0, C_DESL, 0, 0, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_act_rw();
    issue(3'd1, 1, 13'h1ABC, 0, C_ACT, 13'h1ABC, 1, 1'b0, 1'b1, "R4");
    issue(3'd2, 1, 13'h05FF, 0, C_RD, 13'h01FF, 1, 1'b0, 1'b1, "R5");
    issue(3'd3, 1, 13'h0012, 0, C_WR, 13'h0012, 1, 1'b0, 1'b1, "R5");
    issue(3'd1, 1, 13'h0003, 0, C_DESL, 0, 0, 1'b1, 1'b1, "R4");
    issue(3'd2, 2, 13'h0004, 0, C_DESL, 0, 0, 1'b1, 1'b1, "R6");
    issue(3'd3, 0, 13'h0004, 0, C_DESL, 0, 0, 1'b1, 1'b1, "R6");
    // the rejected re-activate left bank 1 open
    issue(3'd3, 1, 13'h1400, 0, C_WR, 13'h1000, 1, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_pre();
    issue(3'd1, 2, 13'h0007, 0, C_ACT, 13'h0007, 2, 1'b0, 1'b1, "R4");
    issue(3'd4, 1, 13'h1FFF, 0, C_PRE, 0, 1, 1'b0, 1'b1, "R7");
    issue(3'd2, 1, 13'h0001, 0, C_DESL, 0, 0, 1'b1, 1'b1, "R7");
    issue(3'd2, 2, 13'h0001, 0, C_RD, 13'h0001, 2, 1'b0, 1'b1, "R7");
    issue(3'd1, 3, 13'h0100, 0, C_ACT, 13'h0100, 3, 1'b0, 1'b1, "R4");
    issue(3'd5, 2, 13'h0000, 0, C_PRE, 13'h0400, 0, 1'b0, 1'b1, "R8");
    issue(3'd2, 2, 13'h0001, 0, C_DESL, 0, 0, 1'b1, 1'b1, "R8");
    issue(3'd3, 3, 13'h0001, 0, C_DESL, 0, 0, 1'b1, 1'b1, "R8");
    issue(3'd1, 2, 13'h0055, 0, C_ACT, 13'h0055, 2, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_refresh();
    issue(3'd6, 0, 0, 0, C_REF, 0, 0, 1'b0, 1'b1, "R9");
    check("R9", "cke_held", int'(cke), 1);
  endtask

  task automatic t_self();
    // bank 2 is open from t_pre
    issue(3'd7, 0, 0, 0, C_REF, 0, 0, 1'b0, 1'b0, "R10");
    check("R10", "cke_stays_low", int'(cke), 0);
    issue(3'd2, 2, 13'h0001, 0, C_DESL, 0, 0, 1'b1, 1'b0, "R10");
    issue(3'd1, 0, 13'h0001, 0, C_DESL, 0, 0, 1'b1, 1'b0, "R10");
    issue(3'd6, 0, 0, 0, C_DESL, 0, 0, 1'b1, 1'b0, "R10");
    issue(3'd7, 0, 0, 0, C_DESL, 0, 0, 1'b0, 1'b1, "R10");
    issue(3'd2, 2, 13'h0001, 0, C_DESL, 0, 0, 1'b1, 1'b1, "R10");
    issue(3'd1, 2, 13'h0009, 0, C_ACT, 13'h0009, 2, 1'b0, 1'b1, "R10");
  endtask

  task automatic t_back_to_back();
    // valid held high: second request waits for the ready bubble
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd6; req_bank = 0; req_addr = 0;
    @(posedge clk);
    @(negedge clk);
    check("R11", "first_cmd", int'(pins()), int'(C_REF));
    @(posedge clk);
    @(negedge clk);
    check("R11", "bubble", int'(pins()), int'(C_DESL));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11", "second_cmd", int'(pins()), int'(C_REF));
    @(posedge clk);
    @(negedge clk);
    check("R11", "settle", int'(pins()), int'(C_DESL));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode();
    t_act_rw();
    t_pre();
    t_refresh();
    t_self();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule